// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Saturating Direction Counters

This block sits beside the fetch program counter and answers, in the same cycle, whether the instruction at that address is a control transfer that should redirect fetch. It is a direct-mapped table. The low-order bits of the fetch address pick one slot. The slot holds the complete address of the branch or jump it describes, the destination address, and a two-bit saturating direction counter. When the stored address matches and the counter leans taken, the block drives the stored destination as the next fetch address. In every other case it drives the fetch address plus one, since addresses count instruction words. A correct prediction therefore costs no bubble.

A resolve port is fed from the stage that works out the real outcome of each control transfer. It carries the instruction's address, whether it was a jump, whether a branch was taken, the real destination, and the next address that fetch had used after it. From this the block trains the counter of a matching slot. A taken branch or a jump that found no slot claims one, and that slot starts in the weak-taken state. The block also flags a misprediction in the same cycle so that the pipeline can restart fetch at the right address. The resolve port follows valid/ready rules, but the table takes one update per cycle and never pushes back: ready is held high outside reset, and a beat counts whenever valid is high.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is empty. Any fetch address misses, `pred_taken` is 0 and `pred_next_pc` equals the fetch address plus 1.
- R2: A lookup hits only when the stored full address equals the fetch address. Another address with the same low 4 index bits misses.
- R3: On a hit whose counter is 2 or 3, `pred_taken` is 1 and `pred_next_pc` is the stored destination, in the same cycle as the fetch address. On a hit with counter 0 or 1, and on a miss, it is the fetch address plus 1.
- R4: A resolve that hits its slot moves the counter up by one when the transfer was taken or was a jump, saturating at 3. It moves the counter down by one when a branch was not taken, saturating at 0. A taken outcome also refreshes the stored destination.
- R5: A jump or taken branch that misses writes its address, its destination and counter value 2 into its slot. The next lookup of that address predicts taken to that destination.
- R6: A not-taken branch that misses leaves the table unchanged.
- R7: `mispredict` is 1 exactly when `rs_valid` is 1 and the real next address differs from `rs_pred_next`. The real next address is `rs_target` when the transfer was taken or was a jump, and `rs_pc`+1 otherwise. `rs_ready` is 1 whenever reset is not asserted.
- R8: When a lookup and a resolve write touch the same slot in one cycle, the lookup returns the contents held before the write. The write is visible from the next cycle.
- R9: An allocation into a slot that holds a different address replaces that slot. The old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| fetch_hit | output | 1 | Slot for fetch_pc holds that exact address |
| pred_taken | output | 1 | Fetch should redirect to the stored destination |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | Resolve beat present |
| rs_ready | output | 1 | Resolve beat accepted (always high outside reset) |
| rs_pc | input | PC_W | Address of the resolved control transfer |
| rs_jump | input | 1 | Resolved instruction is an unconditional jump |
| rs_taken | input | 1 | Resolved branch was taken |
| rs_target | input | PC_W | Real destination address |
| rs_pred_next | input | PC_W | Next address fetch used after this instruction |
| mispredict | output | 1 | Real next address differs from rs_pred_next |

## Verification
A wrong counter value shows up as a flipped `pred_taken` on the very next lookup of that address, one cycle after the resolve that wrote it. A wrong tag or a valid bit that was never set shows up at once as a false hit or a false miss on `fetch_hit`. Saturation faults only show after a run of three or more like outcomes. The bench therefore walks one slot through both ends of the counter range and reads the direction back after each step. Aliased addresses and same-cycle read/write collisions are driven on purpose, because a direct-mapped table hides its tag and timing faults until two addresses meet in one slot.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'd0;
  localparam ctr_t CTR_WEAK_T    = 2'd2;
  localparam ctr_t CTR_STRONG_T  = 2'd3;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == CTR_STRONG_T) ? c : c + 2'd1;
    else    return (c == CTR_STRONG_NT) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_leans_taken(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rda_idx,
  output logic             rda_valid,
  output logic [PC_W-1:0]  rda_tag,
  output logic [PC_W-1:0]  rda_tgt,
  output ctr_t             rda_ctr,
  input  logic [IDX_W-1:0] rdb_idx,
  output logic             rdb_valid,
  output logic [PC_W-1:0]  rdb_tag,
  output logic [PC_W-1:0]  rdb_tgt,
  output ctr_t             rdb_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  ctr_t             wr_ctr
);
  localparam int ENTRIES = 1 << IDX_W;

  logic            valid_q [ENTRIES];
  logic [PC_W-1:0] tag_q   [ENTRIES];
  logic [PC_W-1:0] tgt_q   [ENTRIES];
  ctr_t            ctr_q   [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        tgt_q[g]   <= '0;
        ctr_q[g]   <= CTR_STRONG_NT;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag;
        tgt_q[g]   <= wr_tgt;
        ctr_q[g]   <= wr_ctr;
      end
    end
  end

  // reads return pre-edge contents (R8)
  assign rda_valid = valid_q[rda_idx];
  assign rda_tag   = tag_q[rda_idx];
  assign rda_tgt   = tgt_q[rda_idx];
  assign rda_ctr   = ctr_q[rda_idx];
  assign rdb_valid = valid_q[rdb_idx];
  assign rdb_tag   = tag_q[rdb_idx];
  assign rdb_tgt   = tgt_q[rdb_idx];
  assign rdb_ctr   = ctr_q[rdb_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
              && ctr_q[$past(wr_idx)] == $past(wr_ctr)); // R5
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_tag,
  input  logic [PC_W-1:0] ent_tgt,
  input  ctr_t            ent_ctr,
  output logic            hit,
  output logic            taken,
  output logic [PC_W-1:0] next_pc
);
  assign hit     = ent_valid && (ent_tag == fetch_pc);
  assign taken   = hit && ctr_leans_taken(ent_ctr);
  assign next_pc = taken ? ent_tgt : fetch_pc + PC_W'(1);

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> hit); // R3
  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> next_pc == fetch_pc + PC_W'(1)); // R1
endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_jump,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_target,
  input  logic             ent_valid,
  input  logic [PC_W-1:0]  ent_tag,
  input  logic [PC_W-1:0]  ent_tgt,
  input  ctr_t             ent_ctr,
  output logic             rs_hit,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [PC_W-1:0]  wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output ctr_t             wr_ctr
);
  logic went;
  assign went   = rs_taken | rs_jump;
  assign rs_hit = ent_valid && (ent_tag == rs_pc);
  assign wr_idx = rs_pc[IDX_W-1:0];
  assign wr_tag = rs_pc;

  always_comb begin
    wr_en  = 1'b0;
    wr_tgt = ent_tgt;
    wr_ctr = ent_ctr;
    if (rs_valid) begin
      if (rs_hit) begin
        wr_en  = 1'b1;
        wr_ctr = ctr_step(ent_ctr, went);
        if (went) wr_tgt = rs_target;
      end else if (went) begin
        wr_en  = 1'b1;
        wr_ctr = CTR_WEAK_T;
        wr_tgt = rs_target;
      end
    end
  end

  AST_TOP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit && went && ent_ctr == CTR_STRONG_T) |-> wr_ctr == CTR_STRONG_T); // R4
  AST_BOTTOM_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit && !went && ent_ctr == CTR_STRONG_NT) |-> wr_ctr == CTR_STRONG_NT); // R4
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            fetch_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            rs_valid,
  output logic            rs_ready,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_jump,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic [PC_W-1:0] rs_pred_next,
  output logic            mispredict
);
  logic             fa_valid, fb_valid;
  logic [PC_W-1:0]  fa_tag, fa_tgt, fb_tag, fb_tgt;
  ctr_t             fa_ctr, fb_ctr;
  logic             wr_en, rs_hit;
  logic [IDX_W-1:0] wr_idx;
  logic [PC_W-1:0]  wr_tag, wr_tgt;
  ctr_t             wr_ctr;
  logic [PC_W-1:0]  real_next;

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rda_idx(fetch_pc[IDX_W-1:0]), .rda_valid(fa_valid), .rda_tag(fa_tag),
    .rda_tgt(fa_tgt), .rda_ctr(fa_ctr),
    .rdb_idx(rs_pc[IDX_W-1:0]), .rdb_valid(fb_valid), .rdb_tag(fb_tag),
    .rdb_tgt(fb_tgt), .rdb_ctr(fb_ctr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  btb_lookup #(.PC_W(PC_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .ent_valid(fa_valid), .ent_tag(fa_tag), .ent_tgt(fa_tgt), .ent_ctr(fa_ctr),
    .hit(fetch_hit), .taken(pred_taken), .next_pc(pred_next_pc)
  );

  btb_update #(.PC_W(PC_W), .IDX_W(IDX_W)) u_update (
    .clk(clk), .rst_n(rst_n), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_jump(rs_jump), .rs_taken(rs_taken), .rs_target(rs_target),
    .ent_valid(fb_valid), .ent_tag(fb_tag), .ent_tgt(fb_tgt), .ent_ctr(fb_ctr),
    .rs_hit(rs_hit), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  assign rs_ready   = rst_n;
  assign real_next  = (rs_taken | rs_jump) ? rs_target : rs_pc + PC_W'(1);
  assign mispredict = rs_valid && (real_next != rs_pred_next);

  AST_MISP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !mispredict); // R7
  AST_ALLOC_PREDICTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rs_valid && (rs_taken | rs_jump) && !rs_hit)
     && fetch_pc == $past(rs_pc))
    |-> pred_taken && pred_next_pc == $past(rs_target)); // R5
  AST_NT_MISS_STAYS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rs_valid && !rs_taken && !rs_jump && !rs_hit)
     && fetch_pc == $past(rs_pc))
    |-> !fetch_hit); // R6
endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb_top;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic fetch_hit, pred_taken, rs_ready, mispredict;
  logic [PC_W-1:0] pred_next_pc;
  logic rs_valid = 1'b0, rs_jump = 1'b0, rs_taken = 1'b0;
  logic [PC_W-1:0] rs_pc = '0, rs_target = '0, rs_pred_next = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the table
  bit            m_v   [N];
  logic [31:0]   m_tag [N];
  logic [31:0]   m_tgt [N];
  int            m_ctr [N];

  always #2.5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_pc(rs_pc), .rs_jump(rs_jump), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_next(rs_pred_next), .mispredict(mispredict)
  );

  function automatic bit m_hit(logic [31:0] pc);
    return m_v[pc[IDX_W-1:0]] && m_tag[pc[IDX_W-1:0]] == pc;
  endfunction
  function automatic bit m_taken(logic [31:0] pc);
    return m_hit(pc) && m_ctr[pc[IDX_W-1:0]] >= 2;
  endfunction
  function automatic logic [31:0] m_next(logic [31:0] pc);
    return m_taken(pc) ? m_tgt[pc[IDX_W-1:0]] : pc + 32'd1;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, update model
  task automatic step(logic [31:0] fpc, bit rv, logic [31:0] rpc, bit rj, bit rt,
                      logic [31:0] rtgt, logic [31:0] rpn, string req);
    bit went;
    logic [31:0] real_n;
    int i;
    @(negedge clk);
    fetch_pc = fpc; rs_valid = rv; rs_pc = rpc; rs_jump = rj; rs_taken = rt;
    rs_target = rtgt; rs_pred_next = rpn;
    #1;
    chk(fetch_hit == m_hit(fpc), req, 32'(fetch_hit), 32'(m_hit(fpc)));
    chk(pred_taken == m_taken(fpc), req, 32'(pred_taken), 32'(m_taken(fpc)));
    chk(pred_next_pc == m_next(fpc), req, pred_next_pc, m_next(fpc));
    chk(rs_ready == 1'b1, "R7", 32'(rs_ready), 32'd1);
    went = rj | rt;
    real_n = went ? rtgt : rpc + 32'd1;
    chk(mispredict == (rv && real_n != rpn), "R7", 32'(mispredict), 32'(rv && real_n != rpn));
    if (rv) begin
      i = int'(rpc[IDX_W-1:0]);
      if (m_hit(rpc)) begin
        if (went) begin
          m_ctr[i] = (m_ctr[i] == 3) ? 3 : m_ctr[i] + 1;
          m_tgt[i] = rtgt;
        end else m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
      end else if (went) begin
        m_v[i] = 1; m_tag[i] = rpc; m_tgt[i] = rtgt; m_ctr[i] = 2;
      end
    end
  endtask

  task automatic look(logic [31:0] fpc, string req);
    step(fpc, 0, 32'h0, 0, 0, 32'h0, 32'h0, req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin m_v[k] = 0; m_tag[k] = '0; m_tgt[k] = '0; m_ctr[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    look(32'h0000_0104, "R1");
    look(32'h0000_0ABF, "R1");
    // R6: not-taken miss allocates nothing, mispredict when fetch had guessed taken
    step(32'h0, 1, 32'h0000_0100, 0, 0, 32'h0000_0900, 32'h0000_0900, "R6");
    look(32'h0000_0100, "R6");
    // R5/R3: taken miss allocates weak taken, then predicts
    step(32'h0, 1, 32'h0000_0104, 0, 1, 32'h0000_0200, 32'h0000_0105, "R5");
    look(32'h0000_0104, "R3");
    // R2: alias on index 4 misses
    look(32'h0000_0114, "R2");
    // R8: same-slot lookup during a not-taken update sees old (taken) contents
    step(32'h0000_0104, 1, 32'h0000_0104, 0, 0, 32'h0000_0200, 32'h0000_0200, "R8");
    look(32'h0000_0104, "R4"); // now counter 1: not taken
    // R4: climb to top and saturate
    step(32'h0, 1, 32'h0000_0104, 0, 1, 32'h0000_0208, 32'h0000_0105, "R4"); // 2, new target
    look(32'h0000_0104, "R4");
    step(32'h0, 1, 32'h0000_0104, 0, 1, 32'h0000_0208, 32'h0000_0208, "R4"); // 3
    step(32'h0, 1, 32'h0000_0104, 0, 1, 32'h0000_0208, 32'h0000_0208, "R4"); // stays 3
    step(32'h0, 1, 32'h0000_0104, 0, 0, 32'h0000_0208, 32'h0000_0208, "R4"); // 2
    look(32'h0000_0104, "R4");
    step(32'h0, 1, 32'h0000_0104, 0, 0, 32'h0000_0208, 32'h0000_0208, "R4"); // 1
    step(32'h0, 1, 32'h0000_0104, 0, 0, 32'h0000_0208, 32'h0000_0105, "R4"); // 0
    step(32'h0, 1, 32'h0000_0104, 0, 0, 32'h0000_0208, 32'h0000_0105, "R4"); // stays 0
    step(32'h0, 1, 32'h0000_0104, 0, 1, 32'h0000_0208, 32'h0000_0105, "R4"); // 1
    look(32'h0000_0104, "R4");
    step(32'h0, 1, 32'h0000_0104, 0, 1, 32'h0000_0208, 32'h0000_0105, "R4"); // 2
    look(32'h0000_0104, "R4");
    // R9: jump into same slot evicts
    step(32'h0, 1, 32'h0000_0114, 1, 0, 32'h0000_0300, 32'h0000_0115, "R9");
    look(32'h0000_0104, "R9");
    look(32'h0000_0114, "R9");

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] rp, fp, tg, pn;
      bit rv, rj, rt;
      rp = {24'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      fp = ($urandom_range(0, 1) == 1) ? rp
           : {24'h0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      rv = ($urandom_range(0, 3) != 0);
      rj = ($urandom_range(0, 5) == 0);
      rt = ($urandom_range(0, 2) != 0);
      tg = {20'h0, 4'($urandom_range(1, 3)), 8'($urandom)};
      pn = ($urandom_range(0, 3) != 0) ? m_next(rp) : 32'($urandom);
      step(fp, rv, rp, rj, rt, tg, pn, "R3");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule